// File: doc/BRIEF.md
# Instanced Attribute Index Unit

This unit maps a linear thread index onto the element index used to fetch a per-vertex or per-instance attribute. Each index arrives on a valid/ready stream together with its own configuration: a mode, a shift amount, a small extra field and a 32-bit multiplier. The unit returns one 32-bit element index per accepted index, in order, through a two-register pipeline.

There are four modes. Pass-through returns the index unchanged. Modulo reduces the index by `(2*extra+1) << shift`, where the odd factor is one of 1, 3, 5, 7 or 9. Shift-divide divides by a power of two. Magic-divide divides by an arbitrary constant. It does this with a multiplier whose top bit is always taken as set, an optional round-down correction, and no pre-shift. The constants are computed elsewhere, and address arithmetic happens downstream.

Top module: `aidx_unit`

## Requirements
- R1: With mode 0 (pass-through), the output equals the input index. The shift, extra and multiplier inputs have no effect.
- R2: With mode 1 (modulo), the output is `idx mod ((2*e+1) << shift)`. Here `e` is the extra field, and any value above 4 is treated as 4, so the odd factor is 1, 3, 5, 7 or 9.
- R3: With mode 2 (shift-divide), the output is `idx >> shift`.
- R4: With mode 3 (magic-divide), bit 31 of the multiplier is treated as 1 whatever value is supplied.
- R5: With mode 3 and extra not equal to 1, the output is the upper 32 bits of `idx * mult`, shifted right by `shift`. No shift is applied to `idx` before the multiply.
- R6: With mode 3 and extra equal to 1, the output is the upper 32 bits of `(idx+1) * mult`, shifted right by `shift`. It is exact for `idx = 32'hFFFFFFFF`.
- R7: Latency is fixed. If an index is accepted on clock edge k with out_ready held high, the result is valid after edge k+1.
- R8: While out_valid is high and out_ready is low, out_valid and out_idx stay stable. Every accepted index yields exactly one output, in order.
- R9: After reset, out_valid is low and in_ready is high.
- R10: The configuration is sampled together with each index, so consecutive indices may use different modes and constants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input index valid |
| in_ready_o | output | 1 | Unit can accept an index |
| in_idx_i | input | 32 | Linear thread index |
| cfg_mode_i | input | 2 | 0 pass, 1 modulo, 2 shift-divide, 3 magic-divide |
| cfg_shift_i | input | 5 | Shift amount |
| cfg_extra_i | input | 3 | Odd-factor selector (modulo) or round-down flag (magic) |
| cfg_mult_i | input | 32 | Magic multiplier; bit 31 is ignored and taken as 1 |
| out_valid_o | output | 1 | Element index valid |
| out_ready_i | input | 1 | Consumer accepts the element index |
| out_idx_o | output | 32 | Element index |

## Verification
The bench targets the all-ones index in several modes:
- In magic-divide with round-down, an unwidened `(idx+1)` wraps to zero and returns 0 instead of 0x55555555.
- In modulo by 3, a faulty digit-sum reduction shows up because 2^32-1 is divisible by 3.

Random divisors are converted to magic constants using the floor/remainder rule. The results are compared against exact division, with bit 31 of the multiplier sometimes cleared. If the implicit top bit were dropped, the quotient would be roughly halved.

The clamp of extra values above 4 is also covered: a design without it would reduce by 15 instead of 9.

Random back-pressure checks two failure modes. A broken stall would change or drop held data. A broken pipeline handshake would make the output count differ from the input count.

// File: rtl/aidx_pkg.sv
package aidx_pkg;
  typedef enum logic [1:0] {
    AM_PASS  = 2'd0,
    AM_MOD   = 2'd1,
    AM_SHR   = 2'd2,
    AM_MAGIC = 2'd3
  } aidx_mode_e;

  localparam int unsigned DIGIT_W = 12;  // 2^12 == 1 mod 3, 5, 7 and 9
endpackage

// File: rtl/aidx_pipe_reg.sv
module aidx_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  assign ready_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (ready_o) begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  p_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o);
endmodule

// File: rtl/aidx_digit_sum.sv
module aidx_digit_sum #(
  parameter int unsigned W     = 32,
  parameter int unsigned SUM_W = 15
) (
  input  logic [W-1:0]     x_i,
  output logic [SUM_W-1:0] sum_o
);
  import aidx_pkg::*;
  localparam int unsigned NDIG  = (W + DIGIT_W - 1) / DIGIT_W;
  localparam int unsigned PAD_W = NDIG * DIGIT_W;

  logic [PAD_W-1:0] xp;
  assign xp = PAD_W'(x_i);

  logic [DIGIT_W-1:0] dig [NDIG];
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign dig[g] = xp[g*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NDIG; i++) sum_o = sum_o + SUM_W'(dig[i]);
  end
endmodule

// File: rtl/aidx_odd_mod.sv
module aidx_odd_mod #(
  parameter int unsigned SUM_W = 15
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic [3:0]       k_i,
  output logic [3:0]       rem_o
);
  always_comb begin
    unique case (k_i)
      4'd3:    rem_o = 4'(sum_i % SUM_W'(3));
      4'd5:    rem_o = 4'(sum_i % SUM_W'(5));
      4'd7:    rem_o = 4'(sum_i % SUM_W'(7));
      4'd9:    rem_o = 4'(sum_i % SUM_W'(9));
      default: rem_o = 4'd0;
    endcase
  end
endmodule

// File: rtl/aidx_unit.sv
module aidx_unit #(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned SH_W  = $clog2(IDX_W),
  parameter int unsigned EX_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IDX_W-1:0] in_idx_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [SH_W-1:0]  cfg_shift_i,
  input  logic [EX_W-1:0]  cfg_extra_i,
  input  logic [IDX_W-1:0] cfg_mult_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [IDX_W-1:0] out_idx_o
);
  import aidx_pkg::*;
  localparam int unsigned NDIG  = (IDX_W + DIGIT_W - 1) / DIGIT_W;
  localparam int unsigned SUM_W = DIGIT_W + $clog2(NDIG) + 1;
  localparam int unsigned PRD_W = 2 * IDX_W;

  typedef struct packed {
    logic [1:0]       mode;
    logic [SH_W-1:0]  sh;
    logic [3:0]       k;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] hi;
    logic [SUM_W-1:0] dsum;
  } stage_a_t;
  localparam int unsigned SA_W = $bits(stage_a_t);

  // stage A: multiply and digit-sum
  logic [IDX_W-1:0] shifted, eff, corr;
  logic [PRD_W-1:0] prod;
  logic [EX_W-1:0]  kf;
  logic [SUM_W-1:0] dsum;
  stage_a_t         a_d, a_q;
  logic             a_valid, a_ready;

  assign shifted = in_idx_i >> cfg_shift_i;
  assign eff     = cfg_mult_i | {1'b1, {(IDX_W-1){1'b0}}};
  assign corr    = (cfg_extra_i == EX_W'(1)) ? eff : '0;
  // (idx+1)*m without widening idx: idx*m + m stays below 2^PRD_W
  assign prod    = PRD_W'(in_idx_i) * PRD_W'(eff) + PRD_W'(corr);
  assign kf      = (cfg_extra_i > EX_W'(4)) ? EX_W'(4) : cfg_extra_i;

  aidx_digit_sum #(.W(IDX_W), .SUM_W(SUM_W)) i_dsum (
    .x_i  (shifted),
    .sum_o(dsum)
  );

  always_comb begin
    a_d.mode = cfg_mode_i;
    a_d.sh   = cfg_shift_i;
    a_d.k    = {kf[2:0], 1'b1};
    a_d.idx  = in_idx_i;
    a_d.hi   = prod[PRD_W-1:IDX_W];
    a_d.dsum = dsum;
  end

  aidx_pipe_reg #(.W(SA_W)) i_reg_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .ready_o(in_ready_o),
    .data_i (a_d),
    .valid_o(a_valid),
    .ready_i(a_ready),
    .data_o (a_q)
  );

  // stage B: small reduction and final shift
  logic [3:0]       rem;
  logic [IDX_W-1:0] low_mask, b_res;

  aidx_odd_mod #(.SUM_W(SUM_W)) i_omod (
    .sum_i(a_q.dsum),
    .k_i  (a_q.k),
    .rem_o(rem)
  );

  assign low_mask = ~({IDX_W{1'b1}} << a_q.sh);

  always_comb begin
    unique case (aidx_mode_e'(a_q.mode))
      AM_PASS:  b_res = a_q.idx;
      AM_MOD:   b_res = (IDX_W'(rem) << a_q.sh) | (a_q.idx & low_mask);
      AM_SHR:   b_res = a_q.idx >> a_q.sh;
      default:  b_res = a_q.hi >> a_q.sh;
    endcase
  end

  aidx_pipe_reg #(.W(IDX_W)) i_reg_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(a_valid),
    .ready_o(a_ready),
    .data_i (b_res),
    .valid_o(out_valid_o),
    .ready_i(out_ready_i),
    .data_o (out_idx_o)
  );

  p_mod_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid && a_q.mode == 2'd1 |-> rem < a_q.k);

  p_shr_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid && a_q.mode == 2'd2 |-> b_res <= a_q.idx);

  p_magic_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid && a_q.mode == 2'd3 |-> b_res <= a_q.idx);
endmodule

// File: tb/test_aidx_unit.sv
module test_aidx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_idx = '0;
  logic [1:0]  cfg_mode = '0;
  logic [4:0]  cfg_shift = '0;
  logic [2:0]  cfg_extra = '0;
  logic [31:0] cfg_mult = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_idx;

  always #4 clk = ~clk;  // 125 MHz

  aidx_unit i_aidx_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_idx_i(in_idx),
    .cfg_mode_i(cfg_mode), .cfg_shift_i(cfg_shift), .cfg_extra_i(cfg_extra),
    .cfg_mult_i(cfg_mult),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_idx_o(out_idx)
  );

  int n_chk = 0, n_fail = 0, n_sent = 0, n_recv = 0, cyc = 0;
  bit bp_en = 1'b0;
  logic [31:0] exp_cur;
  string       req_cur;
  logic [31:0] exp_q[$];
  string       req_q[$];
  bit          prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      report();
    end
  end

  always @(posedge clk) begin
    #1 out_ready = bp_en ? 1'($urandom % 2) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) begin
        exp_q.push_back(exp_cur); req_q.push_back(req_cur); n_sent++;
      end
      if (prev_stall)  // R8 held output
        chk(out_valid && out_idx == prev_data, "R8 hold", {31'd0, out_valid, out_idx},
            {32'd1, prev_data});
      if (out_valid && out_ready) begin
        n_recv++;
        if (exp_q.size() == 0) chk(1'b0, "R8 extra output", out_idx, 0);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          chk(out_idx == e, r, out_idx, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_idx;
    end
  end

  task automatic push(logic [1:0] m, logic [4:0] s, logic [2:0] x, logic [31:0] mu,
                      logic [31:0] idx, logic [31:0] e, string r);
    @(posedge clk); #1;
    cfg_mode = m; cfg_shift = s; cfg_extra = x; cfg_mult = mu; in_idx = idx;
    exp_cur = e; req_cur = r; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic idle();
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    bp_en = 1'b0;
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] m; logic [4:0] s; logic [2:0] x;
    logic [31:0] mu; logic [31:0] idx; logic [31:0] e; logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd7, 3'd5, 32'h12345678, 32'hDEADBEEF, 32'hDEADBEEF, 4'd1}, // R1
    '{2'd1, 5'd3, 3'd4, 32'h0,        32'd70,       32'd70,       4'd2}, // R2 mod 72
    '{2'd1, 5'd3, 3'd4, 32'h0,        32'd100,      32'd28,       4'd2}, // R2
    '{2'd1, 5'd0, 3'd1, 32'h0,        32'hFFFFFFFF, 32'd0,        4'd2}, // R2 mod 3
    '{2'd1, 5'd0, 3'd7, 32'h0,        32'd100,      32'd1,        4'd2}, // R2 clamp to 9
    '{2'd1, 5'd2, 3'd2, 32'h0,        32'd23,       32'd3,        4'd2}, // R2 mod 20
    '{2'd2, 5'd4, 3'd0, 32'h0,        32'h12345678, 32'h01234567, 4'd3}, // R3
    '{2'd2, 5'd0, 3'd3, 32'h0,        32'd5,        32'd5,        4'd3}, // R3
    '{2'd3, 5'd1, 3'd1, 32'hAAAAAAAA, 32'hFFFFFFFF, 32'h55555555, 4'd6}, // R6 /3
    '{2'd3, 5'd1, 3'd1, 32'h2AAAAAAA, 32'hFFFFFFFF, 32'h55555555, 4'd4}, // R4
    '{2'd3, 5'd0, 3'd0, 32'h80000000, 32'h80000001, 32'h40000000, 4'd5}, // R5
    '{2'd3, 5'd0, 3'd1, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 4'd6}  // R6
  };

  task automatic rand_vec(string tag);
    automatic int unsigned mode = $urandom % 4;
    automatic logic [31:0] idx = ($urandom % 8 == 0) ? 32'hFFFFFFFF : $urandom;
    automatic int unsigned s = $urandom % 32;
    automatic int unsigned x = $urandom % 5;
    if (mode == 1) begin
      automatic longint unsigned md = longint'(2 * x + 1) << s;
      push(2'd1, 5'(s), 3'(x), $urandom, idx, 32'(longint'(idx) % md), {tag, " R2"});
    end else if (mode == 2) begin
      push(2'd2, 5'(s), 3'($urandom), $urandom, idx, idx >> s, {tag, " R3"});
    end else if (mode == 3) begin
      automatic longint unsigned d = $urandom_range(100000, 3);
      automatic int unsigned lg = 0;
      automatic longint unsigned p, f, r;
      automatic logic [31:0] mu;
      automatic logic [2:0] ex;
      if ((d & (d - 1)) == 0) d++;
      while ((d >> (lg + 1)) != 0) lg++;
      p = 64'd1 << (lg + 32);
      f = p / d; r = p % d;
      if (r <= (64'd1 << lg)) begin mu = 32'(f); ex = 3'd1; end   // R6 round-down
      else begin mu = 32'(f + 1); ex = 3'd0; end                  // R5
      if ($urandom % 2) mu[31] = 1'b0;                            // R4
      push(2'd3, 5'(lg), ex, mu, idx, 32'(longint'(idx) / d), {tag, " R4/R5/R6 magic"});
    end else begin
      push(2'd0, 5'($urandom), 3'($urandom), $urandom, idx, idx, {tag, " R1"});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R9 reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 after release", {out_valid, in_ready}, 2'b01);

    // table, back to back with changing config (R10)
    for (int i = 0; i < NV; i++)
      push(VECS[i].m, VECS[i].s, VECS[i].x, VECS[i].mu, VECS[i].idx, VECS[i].e,
           $sformatf("R%0d R10 vec%0d", VECS[i].req, i));
    idle();
    drain();

    // R7 fixed latency
    push(2'd2, 5'd1, 3'd0, 32'h0, 32'd64, 32'd32, "R7 value");
    idle();
    @(negedge clk);
    chk(!out_valid, "R7 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid && out_idx == 32'd32, "R7 on time", {out_valid, out_idx}, {1'b1, 32'd32});
    drain();

    for (int i = 0; i < 400; i++) rand_vec("rand");
    idle();
    drain();

    // R8 back-pressure with streaming
    bp_en = 1'b1;
    for (int i = 0; i < 400; i++) rand_vec("bp");
    idle();
    drain();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && n_sent == n_recv, "R8 count", n_recv, n_sent);
    report();
  end
endmodule